// File: doc/BRIEF.md
# Configurable Packet CRC Engine

This block computes a cyclic redundancy check over a byte stream. Each byte comes in with a start-of-packet marker and an end-of-data marker. In transmit mode it digests the packet bytes. One cycle after the final byte is accepted, it emits the finished CRC as a burst of bytes that the framer appends to the packet. In receive mode the last CRC-size bytes of the packet are taken as the received check value and are kept out of the calculation. The engine compares them with its own result, keeps a pass/fail flag, and raises a one-cycle reception event.

Everything about the code is programmable: width (one to four octets), seed, generator polynomial, final XOR value, the first byte of the packet that is covered, per-byte input bit reversal, whole-result bit reversal, and the order in which the check bytes travel. A receive event can be raised for every packet or only for packets that pass. Configuration is expected to stay stable while a packet is in flight.

Top module: `pkt_crc_engine`

## Requirements
- R1: After reset, `out_valid`, `rx_irq` and `crc_ok` are all 0.
- R2: The code width is W = 8 × (effective octet count). The register starts from the low W bits of `cfg_seed`. Each covered byte is shifted in bit 7 first. Whenever the bit leaving the top of the register differs from the data bit, the low W bits of `cfg_poly` are XORed in (the x^W term is implicit). The result is then optionally reflected and finally XORed with the low W bits of `cfg_xorout`.
- R3: `cfg_size` gives the octet count. A value of 0 behaves as 1, and values 5 to 7 behave as 4.
- R4: The start-of-packet byte has index 0. Only bytes whose index is at least `cfg_start` (0 to 15) enter the calculation, and indices saturate at 15.
- R5: With `cfg_refin` = 1, each byte is bit-reversed before it enters the register. With 0 it enters unchanged.
- R6: With `cfg_refout` = 1, the whole W-bit result is bit-reversed before the final XOR. With 0 it is left unchanged.
- R7: In transmit mode (`cfg_rx` = 0), `out_valid` rises one cycle after the last beat is accepted and stays high for exactly the octet count, one CRC byte per cycle. `cfg_msb_first` = 0 sends bits 7:0 first, and 1 sends the most significant byte first.
- R8: Input beats offered while `out_valid` is 1 are ignored and change neither the burst in progress nor any later result.
- R9: In receive mode (`cfg_rx` = 1), the last octet-count bytes of a packet form the received value. They are assembled in the order chosen by `cfg_msb_first` and are excluded from the calculation. One cycle after the last beat, `crc_ok` shows whether the two values are equal, and it holds until the next receive packet ends.
- R10: `rx_irq` pulses for one cycle, one cycle after a receive packet ends. It pulses when the check passes, or always when `cfg_ignore_crc` = 1. It never pulses in transmit mode.
- R11: A start-of-packet beat restarts the calculation from the seed and drops any unfinished packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx | input | 1 | 1 = receive check, 0 = transmit generate |
| cfg_size | input | 3 | CRC length in octets |
| cfg_start | input | 4 | Index of first covered byte |
| cfg_refin | input | 1 | Reverse bits of each input byte |
| cfg_refout | input | 1 | Reverse the whole result |
| cfg_msb_first | input | 1 | CRC byte order on the wire |
| cfg_ignore_crc | input | 1 | Raise receive event even on failure |
| cfg_seed | input | 32 | Initial register value |
| cfg_poly | input | 32 | Generator polynomial without top term |
| cfg_xorout | input | 32 | Final XOR value |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | First byte of packet |
| in_last | input | 1 | Last byte of packet |
| in_byte | input | 8 | Input data byte |
| out_valid | output | 1 | CRC byte present (transmit) |
| out_byte | output | 8 | CRC byte |
| rx_irq | output | 1 | Receive event pulse |
| crc_ok | output | 1 | Last received packet passed |

## Verification
Two standard codes over the ASCII digits 1 to 9 tie the reference model to published check values. One is a 16-bit code, unreflected and sent high byte first. The other is a 32-bit code, reflected and sent low byte first. Separate runs with only input reflection or only output reflection tell the two reflection points apart. Runs with 8, 24 and clamped 32-bit widths and with start offsets of 3 and 15 expose errors in masking, alignment and byte counting. In receive mode, matching and single-bit-corrupted packets, each with both byte orders and with the ignore bit set and clear, separate the compare path from the event decision. Beats offered during a transmit burst, and an abandoned partial packet, show whether stray input can leak into a result.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;

  typedef enum logic {
    ORD_LOW_FIRST  = 1'b0,
    ORD_HIGH_FIRST = 1'b1
  } crc_order_e;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] poly_i,
  input  logic [7:0]   din_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] chain [0:8];

  assign chain[0] = state_i;

  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic fb;
    assign fb           = chain[b][W-1] ^ din_i[7-b];
    assign chain[b+1]   = {chain[b][W-2:0], 1'b0} ^ (fb ? poly_i : '0);
  end

  assign state_o = chain[8];

endmodule

// File: rtl/crc_rx_window.sv
module crc_rx_window #(
  parameter int DEPTH = 4,
  parameter int NB_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_i,
  input  logic                 restart_i,
  input  logic [7:0]           byte_i,
  input  logic                 elig_i,
  input  logic [NB_W-1:0]      depth_i,
  output logic                 pop_o,
  output logic [7:0]           pop_byte_o,
  output logic                 pop_elig_o,
  output logic [DEPTH*8-1:0]   tail_o
);

  localparam int SR_W = DEPTH * 8;

  logic [SR_W-1:0]  sr_q, sr_d;
  logic [DEPTH-1:0] el_q, el_d;
  logic [NB_W-1:0]  cnt_q, cnt_d;
  logic             full;

  assign full = (cnt_q >= depth_i);

  always_comb begin
    pop_byte_o = '0;
    pop_elig_o = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (int'(depth_i) == k + 1) begin
        pop_byte_o = sr_q[8*k +: 8];
        pop_elig_o = el_q[k];
      end
    end
  end

  assign pop_o = push_i & ~restart_i & full;

  always_comb begin
    sr_d = (sr_q << 8) | SR_W'(byte_i);
    el_d = (el_q << 1) | DEPTH'(elig_i);
    if (restart_i)  cnt_d = NB_W'(1);
    else if (full)  cnt_d = depth_i;
    else            cnt_d = cnt_q + 1'b1;
  end

  assign tail_o = sr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      el_q  <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      sr_q  <= sr_d;
      el_q  <= el_d;
      cnt_q <= cnt_d;
    end
  end

  p_window_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  p_pop_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> (cnt_q != '0));

endmodule

// File: rtl/crc_tx_serializer.sv
module crc_tx_serializer #(
  parameter int CRC_BYTES = 4,
  parameter int NB_W      = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [CRC_BYTES*8-1:0] value_i,
  input  logic [NB_W-1:0]        nbytes_i,
  input  logic                   msb_first_i,
  output logic                   valid_o,
  output logic [7:0]             byte_o
);

  localparam int CRC_W = CRC_BYTES * 8;
  localparam int SH_W  = $clog2(CRC_W + 1);

  logic [CRC_W-1:0] sh_q, sh_d;
  logic             left_q, left_d;
  logic [NB_W-1:0]  rem_q, rem_d;
  logic [SH_W-1:0]  lsh;

  assign lsh = SH_W'(CRC_W - 8 * int'(nbytes_i));

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    rem_d  = rem_q;
    if (load_i) begin
      rem_d  = nbytes_i;
      left_d = msb_first_i;
      sh_d   = msb_first_i ? (value_i << lsh) : value_i;
    end else if (rem_q != '0) begin
      rem_d = rem_q - 1'b1;
      sh_d  = left_q ? (sh_q << 8) : (sh_q >> 8);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      rem_q  <= rem_d;
    end
  end

  assign valid_o = (rem_q != '0);
  assign byte_o  = left_q ? sh_q[CRC_W-1 -: 8] : sh_q[7:0];

  p_burst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rem_q) <= CRC_BYTES);

  p_load_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (rem_q == '0));

endmodule

// File: rtl/pkt_crc_engine.sv
module pkt_crc_engine
  import pkt_crc_pkg::*;
#(
  parameter int CRC_BYTES = 4,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_rx,
  input  logic [2:0]             cfg_size,
  input  logic [IDX_W-1:0]       cfg_start,
  input  logic                   cfg_refin,
  input  logic                   cfg_refout,
  input  logic                   cfg_msb_first,
  input  logic                   cfg_ignore_crc,
  input  logic [CRC_BYTES*8-1:0] cfg_seed,
  input  logic [CRC_BYTES*8-1:0] cfg_poly,
  input  logic [CRC_BYTES*8-1:0] cfg_xorout,
  input  logic                   in_valid,
  input  logic                   in_sop,
  input  logic                   in_last,
  input  logic [7:0]             in_byte,
  output logic                   out_valid,
  output logic [7:0]             out_byte,
  output logic                   rx_irq,
  output logic                   crc_ok
);

  localparam int CRC_W   = CRC_BYTES * 8;
  localparam int NB_W    = $clog2(CRC_BYTES + 1);
  localparam int SH_W    = $clog2(CRC_W + 1);
  localparam int IDX_MAX = (1 << IDX_W) - 1;

  // effective width and alignment
  logic [NB_W-1:0]  nb;
  logic [SH_W-1:0]  shamt;
  logic [CRC_W-1:0] mask, seed_al, poly_al;

  always_comb begin
    if (cfg_size == 3'd0)                 nb = NB_W'(1);
    else if (int'(cfg_size) > CRC_BYTES)  nb = NB_W'(CRC_BYTES);
    else                                  nb = NB_W'(cfg_size);
  end

  assign shamt   = SH_W'(CRC_W - 8 * int'(nb));
  assign mask    = {CRC_W{1'b1}} >> shamt;
  assign seed_al = cfg_seed << shamt;
  assign poly_al = cfg_poly << shamt;

  // beat acceptance and byte index
  logic             accept, end_tx, end_rx;
  logic [IDX_W-1:0] idx_q, idx_d, cur_idx;
  logic             elig_in;

  assign accept  = in_valid & ~out_valid;
  assign end_tx  = accept & in_last & ~cfg_rx;
  assign end_rx  = accept & in_last & cfg_rx;
  assign cur_idx = in_sop ? '0 : idx_q;
  assign elig_in = (cur_idx >= cfg_start);
  assign idx_d   = (cur_idx == IDX_W'(IDX_MAX)) ? cur_idx : cur_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (accept) idx_q <= idx_d;
  end

  // receive delay window keeps the trailing check bytes out of the sum
  logic             pop_v, pop_elig;
  logic [7:0]       pop_byte;
  logic [CRC_W-1:0] tail;

  crc_rx_window #(.DEPTH(CRC_BYTES), .NB_W(NB_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (accept & cfg_rx),
    .restart_i  (in_sop),
    .byte_i     (in_byte),
    .elig_i     (elig_in),
    .depth_i    (nb),
    .pop_o      (pop_v),
    .pop_byte_o (pop_byte),
    .pop_elig_o (pop_elig),
    .tail_o     (tail)
  );

  // shift register, kept left-aligned so the feedback tap is always the top bit
  logic             feed_v;
  logic [7:0]       feed_b, feed_in;
  logic [CRC_W-1:0] state_q, state_d, base, stepped;

  assign feed_v  = cfg_rx ? (pop_v & pop_elig) : (accept & elig_in);
  assign feed_b  = cfg_rx ? pop_byte : in_byte;
  assign feed_in = cfg_refin ? rev8(feed_b) : feed_b;
  assign base    = (accept & in_sop) ? seed_al : state_q;

  crc_byte_step #(.W(CRC_W)) u_step (
    .state_i (base),
    .poly_i  (poly_al),
    .din_i   (feed_in),
    .state_o (stepped)
  );

  assign state_d = feed_v ? stepped : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= '0;
    else if (accept) state_q <= state_d;
  end

  // result: reflect whole word, then final XOR
  logic [CRC_W-1:0] rev_state, final_val;

  for (genvar i = 0; i < CRC_W; i++) begin : g_rev
    assign rev_state[i] = state_d[CRC_W-1-i];
  end

  assign final_val = ((cfg_refout ? rev_state : (state_d >> shamt)) ^ cfg_xorout) & mask;

  // receive compare
  logic [CRC_W-1:0] rcv_lo, rcv;
  logic             match;

  always_comb begin
    rcv_lo = '0;
    for (int k = 0; k < CRC_BYTES; k++) begin
      for (int j = 0; j < CRC_BYTES; j++) begin
        if (k < int'(nb) && j == int'(nb) - 1 - k) rcv_lo[8*k +: 8] = tail[8*j +: 8];
      end
    end
  end

  assign rcv   = (crc_order_e'(cfg_msb_first) == ORD_HIGH_FIRST) ? (tail & mask) : rcv_lo;
  assign match = (rcv == final_val);

  logic ok_q, ok_d, irq_q, irq_d;

  always_comb begin
    ok_d  = end_rx ? match : ok_q;
    irq_d = end_rx & (match | cfg_ignore_crc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      irq_q <= irq_d;
    end
  end

  assign crc_ok = ok_q;
  assign rx_irq = irq_q;

  // transmit burst
  crc_tx_serializer #(.CRC_BYTES(CRC_BYTES), .NB_W(NB_W)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (end_tx),
    .value_i     (final_val),
    .nbytes_i    (nb),
    .msb_first_i (cfg_msb_first),
    .valid_o     (out_valid),
    .byte_o      (out_byte)
  );

  p_irq_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(in_valid && in_last && cfg_rx && !out_valid));

  p_irq_needs_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !$past(cfg_ignore_crc)) |-> crc_ok);

  p_burst_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_last && !cfg_rx));

  p_ok_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !end_rx |=> $stable(crc_ok));

  p_no_irq_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rx_irq);

endmodule

// File: tb/sim_pkt_crc_engine.sv
`timescale 1ns/1ps
module sim_pkt_crc_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_rx, cfg_refin, cfg_refout, cfg_msb_first, cfg_ignore_crc;
  logic [2:0]  cfg_size;
  logic [3:0]  cfg_start;
  logic [31:0] cfg_seed, cfg_poly, cfg_xorout;
  logic        in_valid, in_sop, in_last;
  logic [7:0]  in_byte;
  logic        out_valid, rx_irq, crc_ok;
  logic [7:0]  out_byte;

  always #2.5 clk = ~clk;

  pkt_crc_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rx(cfg_rx), .cfg_size(cfg_size),
    .cfg_start(cfg_start), .cfg_refin(cfg_refin), .cfg_refout(cfg_refout),
    .cfg_msb_first(cfg_msb_first), .cfg_ignore_crc(cfg_ignore_crc),
    .cfg_seed(cfg_seed), .cfg_poly(cfg_poly), .cfg_xorout(cfg_xorout),
    .in_valid(in_valid), .in_sop(in_sop), .in_last(in_last), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .rx_irq(rx_irq), .crc_ok(crc_ok)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  string       tag;
  logic [7:0]  exp_q[$];
  logic [7:0]  pkt_q[$];
  logic [7:0]  buf_q[$];
  logic        pend_v, pend_irq, pend_ok, exp_ok;

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [2:0] s);
    if (s == 3'd0) return 1;
    if (s > 3'd4)  return 4;
    return int'(s);
  endfunction

  function automatic logic [31:0] ref_crc(input logic [7:0] d[$], input int cnt, input int nb, input int st);
    longint unsigned msk, c, p, r;
    int w;
    logic [7:0] x;
    w   = 8 * nb;
    msk = (64'd1 << w) - 1;
    c   = cfg_seed & msk;
    p   = cfg_poly & msk;
    for (int i = 0; i < cnt; i++) begin
      if (i >= st) begin
        x = d[i];
        if (cfg_refin) for (int b = 0; b < 8; b++) x[b] = d[i][7-b];
        for (int b = 7; b >= 0; b--) begin
          longint unsigned top;
          top = ((c >> (w - 1)) & 1) ^ longint'(x[b]);
          c   = (c << 1) & msk;
          if (top != 0) c = c ^ p;
        end
      end
    end
    if (cfg_refout) begin
      r = 0;
      for (int j = 0; j < w; j++) if (((c >> j) & 1) != 0) r = r | (64'd1 << (w - 1 - j));
      c = r;
    end
    return 32'((c ^ cfg_xorout) & msk);
  endfunction

  task automatic model_finish();
    int nb, len, dl;
    logic [31:0] c, rcv;
    nb  = eff(cfg_size);
    len = pkt_q.size();
    if (!cfg_rx) begin
      c = ref_crc(pkt_q, len, nb, int'(cfg_start));
      for (int k = 0; k < nb; k++)
        exp_q.push_back(cfg_msb_first ? 8'(c >> (8*(nb-1-k))) : 8'(c >> (8*k)));
    end else begin
      dl  = (len > nb) ? len - nb : 0;
      c   = ref_crc(pkt_q, dl, nb, int'(cfg_start));
      rcv = 0;
      for (int k = 0; k < nb; k++) begin
        if (cfg_msb_first) rcv = (rcv << 8) | 32'(pkt_q[dl+k]);
        else               rcv = rcv | (32'(pkt_q[dl+k]) << (8*k));
      end
      pend_v   = 1'b1;
      pend_ok  = (c == rcv);
      pend_irq = (c == rcv) | cfg_ignore_crc;
    end
  endtask

  task automatic tick(input logic v, input logic s, input logic l, input logic [7:0] b);
    logic busy;
    logic [7:0] e;
    @(negedge clk);
    busy = 1'b0;
    if (exp_q.size() > 0) begin
      busy = 1'b1;
      e = exp_q.pop_front();
      chk(tag, "out_valid", 32'(out_valid), 32'd1);
      chk(tag, "out_byte", 32'(out_byte), 32'(e));
    end else begin
      chk(tag, "out_valid", 32'(out_valid), 32'd0);
    end
    if (pend_v) begin
      chk(tag, "rx_irq", 32'(rx_irq), 32'(pend_irq));
      exp_ok = pend_ok;
      pend_v = 1'b0;
    end else begin
      chk(tag, "rx_irq", 32'(rx_irq), 32'd0);
    end
    chk(tag, "crc_ok", 32'(crc_ok), 32'(exp_ok));
    in_valid = v; in_sop = s; in_last = l; in_byte = b;
    if (v && !busy) begin
      if (s) pkt_q.delete();
      pkt_q.push_back(b);
      if (l) model_finish();
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic send_buf();
    for (int i = 0; i < buf_q.size(); i++)
      tick(1'b1, i == 0, i == buf_q.size() - 1, buf_q[i]);
    idle(6);
  endtask

  task automatic fill(input int n, input int s);
    buf_q.delete();
    for (int i = 0; i < n; i++) buf_q.push_back(8'((i * 37 + s * 11 + 5) & 255));
  endtask

  task automatic fill_digits();
    buf_q.delete();
    for (int i = 0; i < 9; i++) buf_q.push_back(8'(8'h31 + i));
  endtask

  task automatic rx_buf(input bit bad);
    int nb;
    logic [31:0] c;
    nb = eff(cfg_size);
    c  = ref_crc(buf_q, buf_q.size(), nb, int'(cfg_start));
    if (bad) buf_q[buf_q.size()-1] = buf_q[buf_q.size()-1] ^ 8'h01;
    for (int k = 0; k < nb; k++)
      buf_q.push_back(cfg_msb_first ? 8'(c >> (8*(nb-1-k))) : 8'(c >> (8*k)));
    send_buf();
  endtask

  task automatic set_cfg(input logic rx, input logic [2:0] sz, input logic [3:0] st,
                         input logic ri, input logic ro, input logic msb,
                         input logic [31:0] sd, input logic [31:0] pl, input logic [31:0] xo);
    cfg_rx = rx; cfg_size = sz; cfg_start = st; cfg_refin = ri; cfg_refout = ro;
    cfg_msb_first = msb; cfg_seed = sd; cfg_poly = pl; cfg_xorout = xo;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0; in_byte = 8'h00;
    cfg_ignore_crc = 1'b0;
    set_cfg(1'b0, 3'd2, 4'd0, 1'b0, 1'b0, 1'b1, 32'hFFFF, 32'h1021, 32'h0);
    pend_v = 1'b0; pend_irq = 1'b0; pend_ok = 1'b0; exp_ok = 1'b0;
    tag = "R1";
    repeat (2) @(negedge clk);
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1", "rx_irq in reset", 32'(rx_irq), 32'd0);
    chk("R1", "crc_ok in reset", 32'(crc_ok), 32'd0);
    rst_n = 1'b1;
    idle(3);

    // R2 R7: 16-bit unreflected code, high byte first
    tag = "R2";
    fill_digits();
    chk("R2", "model check value", ref_crc(buf_q, 9, 2, 0), 32'h29B1);
    send_buf();

    // R5 R6: 32-bit reflected code, low byte first
    tag = "R6";
    set_cfg(1'b0, 3'd4, 4'd0, 1'b1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h04C11DB7, 32'hFFFFFFFF);
    fill_digits();
    chk("R6", "model check value", ref_crc(buf_q, 9, 4, 0), 32'hCBF43926);
    send_buf();

    tag = "R5";
    set_cfg(1'b0, 3'd2, 4'd0, 1'b1, 1'b0, 1'b0, 32'h1D0F, 32'h8005, 32'h0000);
    fill(11, 1); send_buf();
    tag = "R6";
    set_cfg(1'b0, 3'd2, 4'd0, 1'b0, 1'b1, 1'b1, 32'h1D0F, 32'h8005, 32'h5A5A);
    fill(11, 1); send_buf();

    // R3: width clamping
    tag = "R3";
    set_cfg(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 32'h00, 32'h07, 32'h55);
    fill(7, 2); send_buf();
    cfg_size = 3'd1; fill(7, 2); send_buf();
    set_cfg(1'b0, 3'd3, 4'd0, 1'b0, 1'b1, 1'b1, 32'hABCDEF, 32'h5D6DCB, 32'h000000);
    fill(13, 3); send_buf();
    set_cfg(1'b0, 3'd6, 4'd0, 1'b0, 1'b0, 1'b1, 32'h12345678, 32'h04C11DB7, 32'h0F0F0F0F);
    fill(10, 4); send_buf();

    // R4: start offset
    tag = "R4";
    set_cfg(1'b0, 3'd2, 4'd3, 1'b0, 1'b0, 1'b1, 32'hFFFF, 32'h1021, 32'h0);
    fill(12, 5); send_buf();
    cfg_start = 4'd15; fill(20, 6); send_buf();

    // R8: beats during the burst are dropped
    tag = "R8";
    cfg_start = 4'd0;
    fill(6, 7);
    for (int i = 0; i < 6; i++) tick(1'b1, i == 0, i == 5, buf_q[i]);
    tick(1'b1, 1'b1, 1'b1, 8'hAA);
    tick(1'b1, 1'b1, 1'b1, 8'h55);
    idle(4);
    fill(5, 8); send_buf();

    // R7: single-byte packet
    tag = "R7";
    set_cfg(1'b0, 3'd4, 4'd0, 1'b1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h04C11DB7, 32'hFFFFFFFF);
    buf_q.delete(); buf_q.push_back(8'hC3); send_buf();

    // R9: receive checks, both orders and widths
    tag = "R9";
    set_cfg(1'b1, 3'd2, 4'd2, 1'b0, 1'b0, 1'b1, 32'hFFFF, 32'h1021, 32'h0);
    fill(10, 9);  rx_buf(1'b0);
    fill(10, 10); rx_buf(1'b1);
    set_cfg(1'b1, 3'd4, 4'd0, 1'b1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h04C11DB7, 32'hFFFFFFFF);
    fill(14, 11); rx_buf(1'b0);
    fill(14, 12); rx_buf(1'b1);
    set_cfg(1'b1, 3'd1, 4'd1, 1'b0, 1'b0, 1'b0, 32'h00, 32'h07, 32'h00);
    fill(4, 13);  rx_buf(1'b0);

    // R10: event decision
    tag = "R10";
    set_cfg(1'b1, 3'd2, 4'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF, 32'h1021, 32'h0);
    cfg_ignore_crc = 1'b1;
    fill(8, 14); rx_buf(1'b1);
    fill(8, 15); rx_buf(1'b0);
    cfg_ignore_crc = 1'b0;
    fill(8, 16); rx_buf(1'b1);

    // R11: restart on start-of-packet
    tag = "R11";
    fill(4, 17);
    for (int i = 0; i < 4; i++) tick(1'b1, i == 0, 1'b0, buf_q[i]);
    fill(9, 18); rx_buf(1'b0);
    set_cfg(1'b0, 3'd2, 4'd0, 1'b0, 1'b0, 1'b1, 32'hFFFF, 32'h1021, 32'h0);
    fill(3, 19);
    for (int i = 0; i < 3; i++) tick(1'b1, i == 0, 1'b0, buf_q[i]);
    fill(7, 20); send_buf();

    idle(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule